// File: doc/BRIEF.md
# Two-Stage Masked Block Write Buffer

This block gathers host word writes into an eight-word staging buffer of 16-bit words, each word split into a low byte lane (bits 7:0) and a high byte lane (bits 15:8). Every byte lane has a mask bit. The bit is set when the lane holds nothing to write, and cleared when the host has written that lane. A transfer command copies the whole staging block, with its mask, into a second holding stage. It then re-masks the staging buffer, so no pending bytes remain there. The host can go on filling the staging buffer while the holding stage drains.

The holding stage offers the 128-bit block to a memory array port with a valid/ready handshake. It also presents a 16-bit byte-enable vector, which is the inverse of the mask, and a 5-bit block address within the array row. The array changes only the enabled bytes. The four command address bits above the block field must be zero. A command with any of them set is refused and flagged. A fill variant of the command also asks the array to return the written block. The returned block is loaded into a read buffer when the write is accepted.

Top module: `mwb_top`

## Requirements
- R1: After reset, cmd_busy, cmd_err, arr_valid and rb_valid are 0, and every mask bit in both stages is set. A transfer issued before any host write therefore presents arr_be == 0.
- R2: A host write (wr_en) to word wr_word (0..7) stores wr_data in each byte lane whose enable is set. wr_lane_en[0] selects bits 7:0 and wr_lane_en[1] selects bits 15:8. Each stored lane becomes pending. In the block, word w sits at arr_data[16w+15:16w], and its lane l has enable bit arr_be[2w+l].
- R3: A command (cmd_valid) accepted while cmd_busy is 0 and cmd_hi is 0 raises arr_valid on the next cycle. The block presented carries arr_blk = cmd_blk, the staging contents, and arr_be set exactly for the lanes pending at the command cycle.
- R4: On an accepted command, every staging mask bit is set. A host write in the same cycle as the command is not part of that transfer and stays pending for the next one.
- R5: A command with cmd_hi != 0 while cmd_busy is 0 is refused. cmd_err is 1 for exactly the next cycle, no array write starts, and the staging pending lanes are kept.
- R6: cmd_busy is 1 while the holding stage has an unaccepted block. Commands during that time are ignored and raise no cmd_err, while host writes are still stored.
- R7: While arr_valid is 1 and arr_ready is 0, arr_blk, arr_data, arr_be and arr_fill hold their values. After a cycle with arr_valid and arr_ready both 1, arr_valid is 0.
- R8: A command with cmd_fill = 1 drives arr_fill = 1. When that write is accepted, the next cycle shows rb_valid = 1, rb_data equal to arr_rdata from the accept cycle, and rb_blk equal to the block address. A write with arr_fill = 0 leaves the read buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host word write strobe |
| wr_word | input | 3 | Word index within the staging block |
| wr_data | input | 16 | Host write data |
| wr_lane_en | input | 2 | Byte lane enables, bit 0 low byte, bit 1 high byte |
| cmd_valid | input | 1 | Transfer command strobe |
| cmd_fill | input | 1 | Transfer also loads the read buffer |
| cmd_blk | input | 5 | Destination block within the row |
| cmd_hi | input | 4 | Address bits above the block field, must be zero |
| cmd_busy | output | 1 | Holding stage occupied, commands ignored |
| cmd_err | output | 1 | One-cycle flag for a refused command |
| arr_valid | output | 1 | Block write request to the array |
| arr_ready | input | 1 | Array accepts the write |
| arr_fill | output | 1 | Array must return the written block |
| arr_blk | output | 5 | Block address of the write |
| arr_data | output | 128 | Block data, word w at bits 16w+15:16w |
| arr_be | output | 16 | Byte enables, inverse of the mask |
| arr_rdata | input | 128 | Written block returned by the array on accept |
| rb_valid | output | 1 | Read buffer holds a block |
| rb_blk | output | 5 | Block address of the read buffer contents |
| rb_data | output | 128 | Read buffer contents |

## Verification
The assertions assume that arr_ready may take any value in any cycle. They also assume that arr_rdata carries the written block in the cycle a fill write is accepted, and that command inputs matter only in cycles where cmd_busy is 0. wr_word is a 3-bit field, so every value selects a real word. The stimulus drives arr_ready at random and presents fresh arr_rdata every cycle. It issues commands regardless of cmd_busy, so the ignore path is exercised, and it sets cmd_hi nonzero on a fraction of commands.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_TAKE   = 2'd1,
        CMD_REJECT = 2'd2,
        CMD_STALL  = 2'd3
    } cmd_kind_e;

    function automatic cmd_kind_e classify_cmd(input logic valid, input logic busy,
                                               input logic hi_clear);
        if (!valid)         return CMD_NONE;
        else if (busy)      return CMD_STALL;
        else if (!hi_clear) return CMD_REJECT;
        else                return CMD_TAKE;
    endfunction

endpackage

// File: rtl/mwb_stage1.sv
module mwb_stage1 #(
    parameter int WORDS  = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int WORD_W   = LANES * LANE_W,
    localparam int BLK_BITS = WORDS * WORD_W,
    localparam int MASK_W   = WORDS * LANES,
    localparam int IDX_W    = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_word,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [LANES-1:0]    wr_lane_en,
    input  logic                clr,
    output logic [BLK_BITS-1:0] data_o,
    output logic [MASK_W-1:0]   mask_o
);

    typedef struct packed {
        logic [BLK_BITS-1:0] data;
        logic [MASK_W-1:0]   mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.mask = '1;
        if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_lane_en[l]) begin
                    st_d.data[int'(wr_word) * WORD_W + l * LANE_W +: LANE_W] =
                        wr_data[l * LANE_W +: LANE_W];
                    st_d.mask[int'(wr_word) * LANES + l] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign mask_o = st_q.mask;

    // R4: hand-off without a same-cycle write leaves nothing pending
    p_remask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !wr_en |=> &st_q.mask);

    // R2: a written low lane becomes pending
    p_lane_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_lane_en[0] |=> !st_q.mask[LANES * int'($past(wr_word))]);

endmodule

// File: rtl/mwb_stage2.sv
module mwb_stage2 #(
    parameter int BLK_BITS = 128,
    parameter int MASK_W   = 16,
    parameter int BLK_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                load_fill,
    input  logic [BLK_W-1:0]    load_blk,
    input  logic [BLK_BITS-1:0] load_data,
    input  logic [MASK_W-1:0]   load_mask,
    output logic                busy,
    output logic                done,
    output logic                arr_valid,
    input  logic                arr_ready,
    output logic                arr_fill,
    output logic [BLK_W-1:0]    arr_blk,
    output logic [BLK_BITS-1:0] arr_data,
    output logic [MASK_W-1:0]   arr_be
);

    typedef struct packed {
        logic                v;
        logic                fill;
        logic [BLK_W-1:0]    blk;
        logic [BLK_BITS-1:0] data;
        logic [MASK_W-1:0]   mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.v && arr_ready) st_d.v = 1'b0;
        if (load) begin
            st_d.v    = 1'b1;
            st_d.fill = load_fill;
            st_d.blk  = load_blk;
            st_d.data = load_data;
            st_d.mask = load_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.v    <= 1'b0;
            st_q.fill <= 1'b0;
            st_q.blk  <= '0;
            st_q.data <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.v;
    assign done      = st_q.v && arr_ready;
    assign arr_valid = st_q.v;
    assign arr_fill  = st_q.fill;
    assign arr_blk   = st_q.blk;
    assign arr_data  = st_q.data;
    assign arr_be    = ~st_q.mask;

    // R6: the decoder never loads an occupied holding stage
    p_no_load_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !st_q.v);

    // R7: request held stable until accepted
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_valid && !arr_ready |=> arr_valid && $stable(arr_data) && $stable(arr_be)
                                    && $stable(arr_blk) && $stable(arr_fill));

    // R7: request drops after acceptance
    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_valid && arr_ready |=> !arr_valid);

endmodule

// File: rtl/mwb_rdbuf.sv
module mwb_rdbuf #(
    parameter int BLK_BITS = 128,
    parameter int BLK_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap,
    input  logic [BLK_W-1:0]    cap_blk,
    input  logic [BLK_BITS-1:0] cap_data,
    output logic                rb_valid,
    output logic [BLK_W-1:0]    rb_blk,
    output logic [BLK_BITS-1:0] rb_data
);

    typedef struct packed {
        logic                v;
        logic [BLK_W-1:0]    blk;
        logic [BLK_BITS-1:0] data;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap) begin
            st_d.v    = 1'b1;
            st_d.blk  = cap_blk;
            st_d.data = cap_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rb_valid = st_q.v;
    assign rb_blk   = st_q.blk;
    assign rb_data  = st_q.data;

    // R8: contents change only on a capture
    p_rb_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(rb_data) && $stable(rb_blk));

endmodule

// File: rtl/mwb_top.sv
module mwb_top #(
    parameter int WORDS  = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    parameter int BLK_W  = 5,
    parameter int HI_W   = 4,
    localparam int WORD_W   = LANES * LANE_W,
    localparam int BLK_BITS = WORDS * WORD_W,
    localparam int MASK_W   = WORDS * LANES,
    localparam int IDX_W    = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_word,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [LANES-1:0]    wr_lane_en,
    input  logic                cmd_valid,
    input  logic                cmd_fill,
    input  logic [BLK_W-1:0]    cmd_blk,
    input  logic [HI_W-1:0]     cmd_hi,
    output logic                cmd_busy,
    output logic                cmd_err,
    output logic                arr_valid,
    input  logic                arr_ready,
    output logic                arr_fill,
    output logic [BLK_W-1:0]    arr_blk,
    output logic [BLK_BITS-1:0] arr_data,
    output logic [MASK_W-1:0]   arr_be,
    input  logic [BLK_BITS-1:0] arr_rdata,
    output logic                rb_valid,
    output logic [BLK_W-1:0]    rb_blk,
    output logic [BLK_BITS-1:0] rb_data
);
    import mwb_pkg::*;

    typedef struct packed {
        logic err;
    } st_t;

    st_t st_d, st_q;

    logic                busy;
    logic                done;
    logic                take;
    logic [BLK_BITS-1:0] s1_data;
    logic [MASK_W-1:0]   s1_mask;
    cmd_kind_e           kind;

    always_comb begin
        kind      = classify_cmd(cmd_valid, busy, cmd_hi == '0);
        take      = (kind == CMD_TAKE);
        st_d      = st_q;
        st_d.err  = (kind == CMD_REJECT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_busy = busy;
    assign cmd_err  = st_q.err;

    mwb_stage1 #(.WORDS(WORDS), .LANES(LANES), .LANE_W(LANE_W)) u_s1 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_word    (wr_word),
        .wr_data    (wr_data),
        .wr_lane_en (wr_lane_en),
        .clr        (take),
        .data_o     (s1_data),
        .mask_o     (s1_mask)
    );

    mwb_stage2 #(.BLK_BITS(BLK_BITS), .MASK_W(MASK_W), .BLK_W(BLK_W)) u_s2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .load_fill (cmd_fill),
        .load_blk  (cmd_blk),
        .load_data (s1_data),
        .load_mask (s1_mask),
        .busy      (busy),
        .done      (done),
        .arr_valid (arr_valid),
        .arr_ready (arr_ready),
        .arr_fill  (arr_fill),
        .arr_blk   (arr_blk),
        .arr_data  (arr_data),
        .arr_be    (arr_be)
    );

    mwb_rdbuf #(.BLK_BITS(BLK_BITS), .BLK_W(BLK_W)) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (done && arr_fill),
        .cap_blk  (arr_blk),
        .cap_data (arr_rdata),
        .rb_valid (rb_valid),
        .rb_blk   (rb_blk),
        .rb_data  (rb_data)
    );

    // R3: an accepted command presents its block next cycle
    p_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_busy && cmd_hi == '0 |=> arr_valid && arr_blk == $past(cmd_blk));

    // R5: a refused command flags an error and starts no write
    p_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_busy && cmd_hi != '0 |=> cmd_err && !arr_valid);

    // R6: no error is raised for a command met while busy
    p_stall_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |=> !cmd_err);

    // R8: an accepted fill write loads the read buffer
    p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_valid && arr_ready && arr_fill |=> rb_valid && rb_data == $past(arr_rdata)
                                               && rb_blk == $past(arr_blk));

endmodule

// File: tb/mwb_top_bench.sv
module mwb_top_bench;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_word = '0;
    logic [15:0]  wr_data = '0;
    logic [1:0]   wr_lane_en = '0;
    logic         cmd_valid = 1'b0;
    logic         cmd_fill = 1'b0;
    logic [4:0]   cmd_blk = '0;
    logic [3:0]   cmd_hi = '0;
    logic         cmd_busy;
    logic         cmd_err;
    logic         arr_valid;
    logic         arr_ready = 1'b0;
    logic         arr_fill;
    logic [4:0]   arr_blk;
    logic [127:0] arr_data;
    logic [15:0]  arr_be;
    logic [127:0] arr_rdata = '0;
    logic         rb_valid;
    logic [4:0]   rb_blk;
    logic [127:0] rb_data;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mwb_top u_mwb_top (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data), .wr_lane_en(wr_lane_en),
        .cmd_valid(cmd_valid), .cmd_fill(cmd_fill), .cmd_blk(cmd_blk), .cmd_hi(cmd_hi),
        .cmd_busy(cmd_busy), .cmd_err(cmd_err),
        .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_fill(arr_fill),
        .arr_blk(arr_blk), .arr_data(arr_data), .arr_be(arr_be), .arr_rdata(arr_rdata),
        .rb_valid(rb_valid), .rb_blk(rb_blk), .rb_data(rb_data)
    );

    // behavioural reference model
    logic [15:0]  m1_word [8];
    bit           m1_pend [8][2];
    bit           m2_v, m2_fill;
    logic [4:0]   m2_blk;
    logic [15:0]  m2_word [8];
    bit           m2_pend [8][2];
    bit           m_err;
    bit           mrb_v;
    logic [4:0]   mrb_blk;
    logic [127:0] mrb_data;

    task automatic model_reset();
        for (int w = 0; w < 8; w++) begin
            m1_word[w] = '0; m2_word[w] = '0;
            for (int l = 0; l < 2; l++) begin m1_pend[w][l] = 0; m2_pend[w][l] = 0; end
        end
        m2_v = 0; m2_fill = 0; m2_blk = '0; m_err = 0;
        mrb_v = 0; mrb_blk = '0; mrb_data = '0;
    endtask

    task automatic model_step();
        bit take, reject, hs;
        take   = cmd_valid && !m2_v && cmd_hi == 0;
        reject = cmd_valid && !m2_v && cmd_hi != 0;
        hs     = m2_v && arr_ready;
        if (hs && m2_fill) begin
            mrb_v = 1; mrb_blk = m2_blk; mrb_data = arr_rdata;
        end
        if (hs) m2_v = 0;
        if (take) begin
            m2_v = 1; m2_fill = cmd_fill; m2_blk = cmd_blk;
            for (int w = 0; w < 8; w++) begin
                m2_word[w] = m1_word[w];
                for (int l = 0; l < 2; l++) begin
                    m2_pend[w][l] = m1_pend[w][l];
                    m1_pend[w][l] = 0;
                end
            end
        end
        m_err = reject;
        if (wr_en) begin
            for (int l = 0; l < 2; l++) begin
                if (wr_lane_en[l]) begin
                    m1_word[wr_word][l*8 +: 8] = wr_data[l*8 +: 8];
                    m1_pend[wr_word][l] = 1;
                end
            end
        end
    endtask

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [127:0] exp_data;
        logic [15:0]  exp_be;
        for (int w = 0; w < 8; w++) begin
            exp_data[w*16 +: 16] = m2_word[w];
            for (int l = 0; l < 2; l++) exp_be[w*2 + l] = m2_pend[w][l];
        end
        chk("R6", "cmd_busy", 128'(cmd_busy), 128'(m2_v));
        chk("R5", "cmd_err", 128'(cmd_err), 128'(m_err));
        chk("R7", "arr_valid", 128'(arr_valid), 128'(m2_v));
        if (m2_v) begin
            chk("R3", "arr_blk", 128'(arr_blk), 128'(m2_blk));
            chk("R2", "arr_data", arr_data, exp_data);
            chk("R4", "arr_be", 128'(arr_be), 128'(exp_be));
            chk("R8", "arr_fill", 128'(arr_fill), 128'(m2_fill));
        end
        chk("R8", "rb_valid", 128'(rb_valid), 128'(mrb_v));
        if (mrb_v) begin
            chk("R8", "rb_blk", 128'(rb_blk), 128'(mrb_blk));
            chk("R8", "rb_data", rb_data, mrb_data);
        end
    endtask

    // drive one cycle at a falling edge, advance, compare at the next falling edge
    task automatic cyc(input bit we, input logic [2:0] ww, input logic [15:0] wd,
                       input logic [1:0] wl, input bit cv, input bit cf,
                       input logic [4:0] cb, input logic [3:0] ch,
                       input bit rdy, input logic [127:0] rd);
        wr_en = we; wr_word = ww; wr_data = wd; wr_lane_en = wl;
        cmd_valid = cv; cmd_fill = cf; cmd_blk = cb; cmd_hi = ch;
        arr_ready = rdy; arr_rdata = rd;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input bit rdy);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, rdy, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] pat_p, pat_q;
        pat_p = {32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888};
        pat_q = {32'hdead_beef, 32'hcafe_f00d, 32'h0bad_c0de, 32'h1234_5678};
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "cmd_busy", 128'(cmd_busy), 0);
        chk("R1", "cmd_err", 128'(cmd_err), 0);
        chk("R1", "arr_valid", 128'(arr_valid), 0);
        chk("R1", "rb_valid", 128'(rb_valid), 0);

        // R1: transfer with nothing written enables no byte
        cyc(0, 0, 0, 0, 1, 0, 5'd2, 0, 0, '0);
        chk("R1", "arr_be after reset", 128'(arr_be), 0);
        idle(1);

        // R2, R3, R4: writes then a command with a same-cycle write
        cyc(1, 3'd3, 16'habcd, 2'b11, 0, 0, 0, 0, 0, '0);
        cyc(1, 3'd0, 16'h9912, 2'b01, 0, 0, 0, 0, 0, '0);
        cyc(1, 3'd5, 16'h5500, 2'b10, 1, 0, 5'd7, 0, 0, '0);
        chk("R3", "arr_be", 128'(arr_be), 128'(16'h00c1));
        chk("R2", "word3", 128'(arr_data[63:48]), 128'(16'habcd));
        chk("R2", "word0 low", 128'(arr_data[7:0]), 128'(8'h12));
        chk("R3", "arr_blk", 128'(arr_blk), 7);

        // R6, R7: command and write while busy
        cyc(1, 3'd1, 16'h0034, 2'b01, 1, 0, 5'd1, 0, 0, '0);
        chk("R6", "busy held", 128'(cmd_busy), 1);
        chk("R6", "no err while busy", 128'(cmd_err), 0);
        chk("R7", "blk held", 128'(arr_blk), 7);
        idle(1);
        chk("R7", "valid after accept", 128'(arr_valid), 0);

        // R5: refused command
        cyc(0, 0, 0, 0, 1, 0, 5'd9, 4'b0100, 0, '0);
        chk("R5", "err pulse", 128'(cmd_err), 1);
        chk("R5", "no write", 128'(arr_valid), 0);
        idle(0);
        chk("R5", "err one cycle", 128'(cmd_err), 0);

        // R4, R5, R6: pending kept across reject, same-cycle and busy writes
        cyc(0, 0, 0, 0, 1, 0, 5'd9, 0, 0, '0);
        chk("R4", "arr_be kept lanes", 128'(arr_be), 128'(16'h0804));
        chk("R6", "busy write stored", 128'(arr_data[23:16]), 128'(8'h34));
        idle(1);

        // R8: fill transfer loads read buffer, plain one leaves it
        cyc(0, 0, 0, 0, 1, 1, 5'd20, 0, 0, '0);
        chk("R8", "arr_fill", 128'(arr_fill), 1);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, pat_p);
        chk("R8", "rb_valid", 128'(rb_valid), 1);
        chk("R8", "rb_blk", 128'(rb_blk), 20);
        chk("R8", "rb_data", rb_data, pat_p);
        cyc(0, 0, 0, 0, 1, 0, 5'd3, 0, 0, '0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, pat_q);
        chk("R8", "rb_data unchanged", rb_data, pat_p);

        // mixed traffic against the reference model
        for (int i = 0; i < 4000; i++) begin
            bit cv;
            logic [3:0] hi;
            cv = ($urandom % 4) == 0;
            hi = (($urandom % 8) == 0) ? 4'(1 + $urandom % 15) : 4'd0;
            cyc(($urandom % 2) == 1, 3'($urandom), 16'($urandom), 2'($urandom),
                cv, ($urandom % 2) == 1, 5'($urandom), hi,
                ($urandom % 2) == 1,
                {$urandom, $urandom, $urandom, $urandom});
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule